// File: doc/BRIEF.md
# Byte-Wide Write-Once Parallel Memory Model

This block is a synthesizable, clocked model of a byte-wide parallel memory that can only clear bits when it is written. A controller or testbench drives active-low chip-select, output-gate and write-strobe inputs. It also drives a flag that says the high programming supply is present, a flag that says a high voltage sits on address line 9, an address bus and a split data bus. From these inputs the model selects an operating mode. It then returns the stored byte, a fixed identifier byte, or nothing, in which case the output enable is low and the bus is high impedance.

Writes follow write-once memory physics: a write strobe ANDs the input byte into the addressed location, so bits can fall from one to zero but never rise. A separate erase input returns every location to all ones. The array depth is set by the address-width parameter, so a small depth can be used in simulation. The outputs are registered and show the effect of the inputs one clock after they are sampled.

Top module: `eprom_model`

## Requirements
- R1: While reset is held and after it is released, every byte holds 0xFF and `dq_oe` is low until a mode that drives the bus is selected.
- R2: Read mode is selected when `ce_n`=0, `oe_n`=0, `vpp_on`=0 and `a9_hv`=0. The byte at `addr` appears on `dq_out` with `dq_oe`=1, and `pgm_n` has no effect.
- R3: When `ce_n`=0, `oe_n`=1 and `vpp_on`=0, `dq_oe` is 0 and no location changes, even if `pgm_n` is low.
- R4: When `ce_n`=1, `dq_oe` is 0 and no location changes, whatever the other control inputs are.
- R5: Program mode is selected when `vpp_on`=1, `ce_n`=0, `oe_n`=1 and `pgm_n`=0. On each clock in this mode, the addressed location becomes its old value AND `dq_in`, and `dq_oe` stays 0.
- R6: Verify mode is selected when `vpp_on`=1, `ce_n`=0, `oe_n`=0, `pgm_n`=1 and `a9_hv`=0. The addressed byte is driven with `dq_oe`=1.
- R7: While `vpp_on`=1 and `ce_n`=0, a combination that is neither program nor verify writes nothing and leaves `dq_oe`=0. This covers `oe_n`=1 with `pgm_n`=1, and `oe_n`=0 with `pgm_n`=0.
- R8: When `ce_n`=0, `oe_n`=0 and `a9_hv`=1, the identifier is driven with `dq_oe`=1. It is 0x97 when `addr[0]`=0 and 0xD6 when `addr[0]`=1, whatever the other address bits are.
- R9: A write never sets a bit. Repeating a strobe with the same data leaves the same value, and a later strobe can clear more bits.
- R10: A clock with `erase`=1 sets every location to 0xFF. Erase takes priority over a program strobe in the same cycle.
- R11: Outputs are registered. The output for inputs sampled at one rising edge appears just after that edge and stays unchanged until the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; erases the array |
| ce_n | input | 1 | Chip select, active low |
| oe_n | input | 1 | Output gate, active low |
| pgm_n | input | 1 | Write strobe, active low |
| vpp_on | input | 1 | Programming supply present |
| a9_hv | input | 1 | High voltage on address line 9 (identifier access) |
| erase | input | 1 | Set whole array to ones |
| addr | input | ADDR_W | Byte address |
| dq_in | input | 8 | Data to write |
| dq_out | output | 8 | Data driven to the bus |
| dq_oe | output | 1 | Bus drive enable; low means high impedance |

## Verification
The assertions assume that the control inputs change only between clock edges and are stable when sampled. They also assume that `addr` stays in range, which holds because its width sets the depth. The bench changes every input on the falling edge. It keeps random addresses mostly inside a 16-byte window so that locations are written many times, and it draws `a9_hv` and `erase` with low probability so that the ordinary modes dominate. Directed sequences cover the identifier with all other address bits set, repeated strobes, and an erase that coincides with a strobe.

// File: rtl/eprom_pkg.sv
package eprom_pkg;

    localparam int BYTE_W = 8;

    typedef enum logic [2:0] {
        MD_STANDBY,
        MD_QUIET,
        MD_READ,
        MD_PROGRAM,
        MD_VERIFY,
        MD_INHIBIT,
        MD_IDENT
    } eprom_mode_e;

    typedef struct packed {
        logic              drive;
        logic [BYTE_W-1:0] data;
    } bus_out_t;

endpackage

// File: rtl/eprom_mode_decode.sv
module eprom_mode_decode
    import eprom_pkg::*;
(
    input  logic        ce_n,
    input  logic        oe_n,
    input  logic        pgm_n,
    input  logic        vpp_on,
    input  logic        a9_hv,
    output eprom_mode_e mode,
    output logic        wr_en
);
    always_comb begin
        if (ce_n) begin
            mode = MD_STANDBY;
        end else if (a9_hv && !oe_n) begin
            mode = MD_IDENT;
        end else if (!vpp_on) begin
            mode = oe_n ? MD_QUIET : MD_READ;
        end else if (!oe_n && pgm_n) begin
            mode = MD_VERIFY;
        end else if (oe_n && !pgm_n) begin
            mode = MD_PROGRAM;
        end else begin
            mode = MD_INHIBIT;
        end
        wr_en = (mode == MD_PROGRAM);
    end
endmodule

// File: rtl/eprom_id_rom.sv
module eprom_id_rom
    import eprom_pkg::*;
#(
    parameter logic [BYTE_W-1:0] MFG_CODE = 8'h97,
    parameter logic [BYTE_W-1:0] DEV_CODE = 8'hD6
) (
    input  logic              sel,
    output logic [BYTE_W-1:0] code
);
    assign code = sel ? DEV_CODE : MFG_CODE;
endmodule

// File: rtl/eprom_cell_array.sv
module eprom_cell_array
    import eprom_pkg::*;
#(
    parameter int ADDR_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              erase,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [BYTE_W-1:0] wr_data,
    output logic [BYTE_W-1:0] rd_data
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [BYTE_W-1:0] mem_q [DEPTH];
    logic [BYTE_W-1:0] cell_d;

    assign rd_data = mem_q[addr];
    // Bits can only fall: new value is old AND incoming byte.
    assign cell_d  = rd_data & wr_data;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= '1;
        end else if (erase) begin
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= '1;
        end else if (wr_en) begin
            mem_q[addr] <= cell_d;
        end
    end

    // R9: a write never raises a bit at the written location
    assert_write_only_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !erase) |=> ((mem_q[$past(addr)] & ~$past(rd_data)) == '0));

    // R10: erase leaves ones at the address presented with it
    assert_erase_sets_ones_R10: assert property (@(posedge clk) disable iff (!rst_n)
        erase |=> (mem_q[$past(addr)] == '1));
endmodule

// File: rtl/eprom_model.sv
module eprom_model
    import eprom_pkg::*;
#(
    parameter int ADDR_W = 10,
    parameter logic [7:0] MFG_CODE = 8'h97,
    parameter logic [7:0] DEV_CODE = 8'hD6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce_n,
    input  logic              oe_n,
    input  logic              pgm_n,
    input  logic              vpp_on,
    input  logic              a9_hv,
    input  logic              erase,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        dq_in,
    output logic [7:0]        dq_out,
    output logic              dq_oe
);
    eprom_mode_e       mode;
    logic              wr_en;
    logic [BYTE_W-1:0] cell_rd;
    logic [BYTE_W-1:0] id_code;
    bus_out_t          out_d, out_q;

    eprom_mode_decode u_dec (
        .ce_n   (ce_n),
        .oe_n   (oe_n),
        .pgm_n  (pgm_n),
        .vpp_on (vpp_on),
        .a9_hv  (a9_hv),
        .mode   (mode),
        .wr_en  (wr_en)
    );

    eprom_cell_array #(.ADDR_W(ADDR_W)) u_array (
        .clk     (clk),
        .rst_n   (rst_n),
        .erase   (erase),
        .wr_en   (wr_en),
        .addr    (addr),
        .wr_data (dq_in),
        .rd_data (cell_rd)
    );

    eprom_id_rom #(.MFG_CODE(MFG_CODE), .DEV_CODE(DEV_CODE)) u_id (
        .sel  (addr[0]),
        .code (id_code)
    );

    always_comb begin
        out_d = '0;
        unique case (mode)
            MD_READ, MD_VERIFY: begin
                out_d.drive = 1'b1;
                out_d.data  = cell_rd;
            end
            MD_IDENT: begin
                out_d.drive = 1'b1;
                out_d.data  = id_code;
            end
            default: out_d = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) out_q <= '0;
        else        out_q <= out_d;
    end

    assign dq_out = out_q.data;
    assign dq_oe  = out_q.drive;

    // R4: deselected chip never drives the bus
    assert_standby_hiz_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ce_n |=> !dq_oe);

    // R3: output gate high without supply keeps the bus released
    assert_quiet_hiz_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!ce_n && oe_n && !vpp_on) |=> !dq_oe);

    // R6: verify combination drives the bus
    assert_verify_drives_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!ce_n && !oe_n && pgm_n && vpp_on && !a9_hv) |=> dq_oe);

    // R8: identifier byte chosen by address bit 0 only
    assert_ident_code_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!ce_n && !oe_n && a9_hv) |=> (dq_oe && dq_out == ($past(addr[0]) ? DEV_CODE : MFG_CODE)));

    // R7: strobe without supply or while deselected never writes
    assert_no_write_outside_program_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (ce_n || !vpp_on || pgm_n) |-> !wr_en);
endmodule

// File: tb/eprom_model_test.sv
`timescale 1ns/1ps
module eprom_model_test;
    localparam int AW    = 10;
    localparam int DEPTH = 1 << AW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ce_n = 1'b1, oe_n = 1'b1, pgm_n = 1'b1;
    logic          vpp_on = 1'b0, a9_hv = 1'b0, erase = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [7:0]    dq_in = '0;
    logic [7:0]    dq_out;
    logic          dq_oe;

    int tests = 0;
    int fails = 0;
    logic [7:0] ref_mem [DEPTH];

    always #2.5 clk = ~clk;

    eprom_model #(.ADDR_W(AW)) uut (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .pgm_n(pgm_n),
        .vpp_on(vpp_on), .a9_hv(a9_hv), .erase(erase), .addr(addr),
        .dq_in(dq_in), .dq_out(dq_out), .dq_oe(dq_oe)
    );

    task automatic check(input string req, input logic got_oe, input logic [7:0] got_d,
                         input logic exp_oe, input logic [7:0] exp_d);
        tests++;
        if (got_oe !== exp_oe || (exp_oe && got_d !== exp_d)) begin
            fails++;
            $display("FAIL %s: oe=%0b data=%02h expected oe=%0b data=%02h",
                     req, got_oe, got_d, exp_oe, exp_d);
        end
    endtask

    // Expected response from the requirement table.
    function automatic void predict(input logic c, o, p, v, h, input logic [AW-1:0] a,
                                    output logic eoe, output logic [7:0] ed,
                                    output string req, output logic wr);
        eoe = 1'b0; ed = 8'h00; wr = 1'b0;
        if (c)                begin req = "R4"; end
        else if (h && !o)     begin req = "R8"; eoe = 1'b1; ed = a[0] ? 8'hD6 : 8'h97; end
        else if (!v && o)     begin req = "R3"; end
        else if (!v)          begin req = "R2"; eoe = 1'b1; ed = ref_mem[a]; end
        else if (!o && p)     begin req = "R6"; eoe = 1'b1; ed = ref_mem[a]; end
        else if (o && !p)     begin req = "R5"; wr = 1'b1; end
        else                  begin req = "R7"; end
    endfunction

    task automatic cyc(input logic c, o, p, v, h, input logic [AW-1:0] a,
                       input logic [7:0] d, input logic e);
        logic eoe; logic [7:0] ed; string req; logic wr;
        ce_n = c; oe_n = o; pgm_n = p; vpp_on = v; a9_hv = h; addr = a; dq_in = d; erase = e;
        predict(c, o, p, v, h, a, eoe, ed, req, wr);
        if (e) begin
            for (int i = 0; i < DEPTH; i++) ref_mem[i] = 8'hFF;
        end else if (wr) begin
            ref_mem[a] = ref_mem[a] & d;
        end
        @(posedge clk);
        @(negedge clk);
        check(e ? "R10" : req, dq_oe, dq_out, eoe, ed);
    endtask

    task automatic rd(input logic [AW-1:0] a);
        cyc(1'b0, 1'b0, 1'b1, 1'b0, 1'b0, a, 8'h00, 1'b0);
    endtask

    initial begin
        #(5.0 * 150000);
        fails++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        for (int i = 0; i < DEPTH; i++) ref_mem[i] = 8'hFF;
        repeat (3) @(negedge clk);
        check("R1", dq_oe, dq_out, 1'b0, 8'h00);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", dq_oe, dq_out, 1'b0, 8'h00);
        rd('0);
        rd(AW'(DEPTH - 1));
        rd(AW'(37));

        // R5 then R9: repeated and narrowing strobes
        cyc(1'b0, 1'b1, 1'b0, 1'b1, 1'b0, AW'(5), 8'hA5, 1'b0);
        cyc(1'b0, 1'b1, 1'b0, 1'b1, 1'b0, AW'(5), 8'hA5, 1'b0);
        cyc(1'b0, 1'b0, 1'b1, 1'b1, 1'b0, AW'(5), 8'h00, 1'b0);
        check("R9", dq_oe, dq_out, 1'b1, 8'hA5);
        cyc(1'b0, 1'b1, 1'b0, 1'b1, 1'b0, AW'(5), 8'hFE, 1'b0);
        rd(AW'(5));
        check("R9", dq_oe, dq_out, 1'b1, 8'hA4);

        // R3/R4/R7: strobes that must not write
        cyc(1'b1, 1'b1, 1'b0, 1'b1, 1'b0, AW'(6), 8'h00, 1'b0);
        cyc(1'b0, 1'b1, 1'b0, 1'b0, 1'b0, AW'(6), 8'h00, 1'b0);
        cyc(1'b0, 1'b0, 1'b0, 1'b1, 1'b0, AW'(6), 8'h00, 1'b0);
        rd(AW'(6));
        check("R7", dq_oe, dq_out, 1'b1, 8'hFF);

        // R8: identifier with every other address bit set
        cyc(1'b0, 1'b0, 1'b1, 1'b0, 1'b1, AW'(DEPTH - 2), 8'h00, 1'b0);
        cyc(1'b0, 1'b0, 1'b1, 1'b0, 1'b1, AW'(DEPTH - 1), 8'h00, 1'b0);
        cyc(1'b0, 1'b0, 1'b0, 1'b1, 1'b1, AW'(0), 8'h00, 1'b0);

        // R11: output holds until the next rising edge
        rd(AW'(5));
        ce_n = 1'b1;
        #1;
        check("R11", dq_oe, dq_out, 1'b1, 8'hA4);
        @(posedge clk); @(negedge clk);
        check("R11", dq_oe, dq_out, 1'b0, 8'h00);

        // R10: erase wins over a concurrent strobe
        cyc(1'b0, 1'b1, 1'b0, 1'b1, 1'b0, AW'(5), 8'h00, 1'b1);
        rd(AW'(5));
        check("R10", dq_oe, dq_out, 1'b1, 8'hFF);

        // Random mix
        for (int n = 0; n < 4000; n++) begin
            logic [AW-1:0] a;
            a = ($urandom % 8 == 0) ? AW'($urandom) : AW'($urandom % 16);
            cyc(($urandom % 6) == 0, $urandom % 2 == 1, $urandom % 2 == 1,
                $urandom % 2 == 1, ($urandom % 10) == 0, a, 8'($urandom),
                ($urandom % 300) == 0);
        end

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule